// File: doc/BRIEF.md
# I2C Enable and Abort Sequencer

This block is the control layer between a memory-mapped register write port and the byte-level engine of an I2C master. It holds two software control bits: a module enable and a transfer-abort request. It turns changes to those bits into an orderly shutdown. The block does not drive SCL or SDA. It only issues requests to the byte engine: a STOP, a forced NACK, and flushes of the transmit and receive FIFOs. It also raises a single-cycle interrupt when an abort has finished.

Software writes the control word. The block samples the engine's status lines: byte boundary, transfer complete, bus idle and direction. A small state machine walks through the abort sequence or the disable sequence. An abort lets the current transfer finish, then stops the bus and flushes the transmit side. A disable depends on direction. A transmit runs to the end of its transfer. A receive is cut at the next byte boundary and that byte is refused with a NACK. A status-valid flag stays high until the bus has gone idle after a disable.

Top module: `i2c_halt_seq`

## Requirements
- R1: After reset, reg_rdata is 0, both flushes are high, and stop_req, nack_req, abort_irq and status_hold are low. Bit 0 of the control word is the enable and bit 1 is the abort request. Bits 31..2 always read 0, whatever was written.
- R2: A write with bit 1 set sets the abort bit only if the enable bit was already 1 before that write. Otherwise bit 1 of the write is dropped.
- R3: Once the abort bit is 1, a software write of 0 to bit 1 leaves it at 1.
- R4: A pending abort waits until the engine reports transfer complete (or the bus is idle). It then drives stop_req and tx_flush together for exactly one cycle.
- R5: In the cycle after that STOP request, readback bit 1 is 0 and abort_irq is high. abort_irq falls again on the following cycle.
- R6: Clearing the enable during a transmit holds tx_flush low until transfer complete. Byte boundaries alone do not end the wait. After transfer complete, tx_flush rises.
- R7: Clearing the enable during a receive drives nack_req while the block waits. The wait ends at the next byte boundary.
- R8: While the sequencer is disabled and idle, tx_flush and rx_flush are both held high.
- R9: After a disable, status_hold stays high until the engine reports bus idle. One cycle later it falls.
- R10: Readback bit 0 always shows the enable value last written. If the enable is cleared while an abort is pending, the abort still completes with its interrupt before status_hold falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| eng_byte_done | input | 1 | Engine: byte boundary reached (pulse) |
| eng_xfer_done | input | 1 | Engine: current transfer complete (pulse) |
| eng_idle | input | 1 | Engine: bus idle (level) |
| eng_is_rx | input | 1 | Engine: current transfer is a receive |
| stop_req | output | 1 | Request a STOP condition |
| tx_flush | output | 1 | Flush / hold-flushed the transmit FIFO |
| rx_flush | output | 1 | Flush / hold-flushed the receive FIFO |
| nack_req | output | 1 | Refuse the byte being received |
| abort_irq | output | 1 | One-cycle abort-finished interrupt |
| status_hold | output | 1 | Interrupt status still valid |
| reg_rdata | output | 32 | Control register readback |

## Verification
The sharpest overlap is a single write that sets the abort bit and clears the enable in the same cycle. The abort is accepted because the gate looks at the enable value from before the write. The disable therefore has to queue behind the abort. The bench provokes this with one write of value 2 while the bus is idle. It then checks, cycle by cycle, that the STOP request and the interrupt come first. It checks that the readback shows the enable at 0 throughout, and that status_hold falls only after the interrupt. A second overlap is the completion cycle of the abort, where the automatic clear takes priority over any write. This one is judged by an assertion that bit 1 may fall only together with the interrupt.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned EN_POS = 0;
  localparam int unsigned AB_POS = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACTIVE, ST_ABORT_WAIT, ST_ABORT_STOP, ST_DISABLE_WAIT, ST_DONE
  } seq_state_t;

  // Next abort bit: completion clears, a gated write sets, otherwise sticky.
  function automatic logic abort_next(input logic cur, input logic wr,
                                      input logic req, input logic en_now,
                                      input logic done);
    if (done) return 1'b0;
    return cur | (wr & req & en_now);
  endfunction

  // Whether a graceful disable may leave its waiting state.
  function automatic logic disable_exit(input logic is_rx, input logic byte_done,
                                        input logic xfer_done, input logic idle);
    return idle | (is_rx ? byte_done : xfer_done);
  endfunction
endpackage

// File: rtl/i2cq_ctl_regs.sv
module i2cq_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_en_bit,
  input  logic wr_abort_bit,
  input  logic abort_done,
  output logic en_q,
  output logic abort_q
);
  import i2cq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (wr) en_q <= wr_en_bit;
      abort_q <= abort_next(abort_q, wr, wr_abort_bit, en_q, abort_done);
    end
  end
endmodule

// File: rtl/i2cq_halt_fsm.sv
module i2cq_halt_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic abort_q,
  input  logic byte_done,
  input  logic xfer_done,
  input  logic idle,
  input  logic is_rx,
  output logic abort_done,
  output logic stop_req,
  output logic tx_flush,
  output logic rx_flush,
  output logic nack_req,
  output logic irq,
  output logic hold
);
  import i2cq_pkg::*;

  seq_state_t state_q, state_d;
  logic       irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:         if (en_q) state_d = ST_ACTIVE;
      ST_ACTIVE:       if (abort_q) state_d = ST_ABORT_WAIT;
                       else if (!en_q) state_d = ST_DISABLE_WAIT;
      ST_ABORT_WAIT:   if (xfer_done || idle) state_d = ST_ABORT_STOP;
      ST_ABORT_STOP:   state_d = en_q ? ST_ACTIVE : ST_DISABLE_WAIT;
      ST_DISABLE_WAIT: if (disable_exit(is_rx, byte_done, xfer_done, idle))
                         state_d = ST_DONE;
      ST_DONE:         if (idle) state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_ABORT_STOP);
    end
  end

  assign abort_done = (state_q == ST_ABORT_STOP);
  assign stop_req   = abort_done;
  assign tx_flush   = (state_q == ST_IDLE) || (state_q == ST_DONE) || abort_done;
  assign rx_flush   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign nack_req   = (state_q == ST_DISABLE_WAIT) && is_rx;
  assign irq        = irq_q;
  assign hold       = (state_q != ST_IDLE);
endmodule

// File: rtl/i2c_halt_seq.sv
module i2c_halt_seq #(
  parameter int unsigned REG_W = i2cq_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             eng_byte_done,
  input  logic             eng_xfer_done,
  input  logic             eng_idle,
  input  logic             eng_is_rx,
  output logic             stop_req,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             nack_req,
  output logic             abort_irq,
  output logic             status_hold,
  output logic [REG_W-1:0] reg_rdata
);
  import i2cq_pkg::*;

  logic en_q, abort_q, abort_done;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;

  i2cq_ctl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .wr_en_bit    (reg_wdata[EN_POS]),
    .wr_abort_bit (reg_wdata[AB_POS]),
    .abort_done   (abort_done),
    .en_q         (en_q),
    .abort_q      (abort_q)
  );

  i2cq_halt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .abort_q    (abort_q),
    .byte_done  (eng_byte_done),
    .xfer_done  (eng_xfer_done),
    .idle       (eng_idle),
    .is_rx      (eng_is_rx),
    .abort_done (abort_done),
    .stop_req   (stop_req),
    .tx_flush   (tx_flush),
    .rx_flush   (rx_flush),
    .nack_req   (nack_req),
    .irq        (abort_irq),
    .hold       (status_hold)
  );

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[EN_POS] = en_q;
    reg_rdata[AB_POS] = abort_q;
  end
endmodule

// File: rtl/i2c_halt_seq_chk.sv
module i2c_halt_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_idle,
  input logic        stop_req,
  input logic        tx_flush,
  input logic        rx_flush,
  input logic        nack_req,
  input logic        abort_irq,
  input logic        status_hold,
  input logic [31:0] reg_rdata
);
  // R2
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && !reg_rdata[1]) |=> !reg_rdata[1]);
  // R3
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] |=> (reg_rdata[1] || abort_irq));
  // R4
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (tx_flush && reg_rdata[1]));
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq |=> !abort_irq);
  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq |-> (!reg_rdata[1] && $past(stop_req)));
  // R7
  nack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |-> (status_hold && !stop_req && !rx_flush));
  // R8
  idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_hold |-> (tx_flush && rx_flush));
  // R9
  hold_until_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_hold) |-> $past(eng_idle));
endmodule

bind i2c_halt_seq i2c_halt_seq_chk u_chk (.*);

// File: tb/i2c_halt_seq_bench.sv
module i2c_halt_seq_bench;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        eng_byte_done = 1'b0, eng_xfer_done = 1'b0;
  logic        eng_idle = 1'b0, eng_is_rx = 1'b0;
  logic        stop_req, tx_flush, rx_flush, nack_req, abort_irq, status_hold;
  logic [31:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_halt_seq u_i2c_halt_seq (.*);

  // {write data, expected readback}, walked from reset with engine busy
  localparam logic [63:0] VEC [7] = '{
    {32'h0000_0002, 32'h0}, // R2 abort while disabled
    {32'h0000_0003, 32'h1}, // R2 abort with enable set in same write
    {32'h0000_0003, 32'h3}, // R2 abort accepted
    {32'h0000_0001, 32'h3}, // R3 clear attempt
    {32'h0000_0000, 32'h2}, // R10 enable cleared, abort pending
    {32'h0000_0002, 32'h2}, // R3 still pending
    {32'hFFFF_FFFD, 32'h3}  // R1 reserved bits read zero
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic logic [31:0] outs();
    return {26'b0, stop_req, tx_flush, rx_flush, nack_req, abort_irq, status_hold};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state; R8 flushes held while idle
    chk("R1 readback", reg_rdata, 32'h0);
    chk("R8 reset outputs {stop,txf,rxf,nack,irq,hold}", outs(), 32'h18);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][63:32]);
      tick();
      chk($sformatf("R1/R2/R3/R10 vector %0d", i), reg_rdata, VEC[i][31:0]);
    end

    // R4: transfer complete releases the abort
    eng_xfer_done = 1'b1; tick(); eng_xfer_done = 1'b0;
    chk("R4 stop with tx flush", {stop_req, tx_flush, abort_irq}, 32'h6);
    chk("R4 abort bit still set during stop", reg_rdata, 32'h3);
    tick();
    chk("R5 irq and auto-clear", {stop_req, abort_irq, reg_rdata[1:0]}, 32'h5);
    tick();
    chk("R5 irq single cycle", abort_irq, 32'h0);

    // R7: disable during receive
    eng_is_rx = 1'b1;
    wr(32'h0);
    chk("R7 no nack before wait", nack_req, 32'h0);
    tick();
    chk("R7 nack while waiting, rx not flushed", {nack_req, rx_flush, status_hold}, 32'h5);
    eng_byte_done = 1'b1; tick(); eng_byte_done = 1'b0;
    chk("R7 byte boundary ends wait", {nack_req, tx_flush, rx_flush}, 32'h3);
    tick(); tick(); tick();
    chk("R9 status held while bus busy", status_hold, 32'h1);
    eng_idle = 1'b1; tick();
    chk("R9 status dropped after idle", status_hold, 32'h0);
    chk("R8 flushes held when disabled", {tx_flush, rx_flush}, 32'h3);
    eng_idle = 1'b0; eng_is_rx = 1'b0;

    // R6: disable during transmit
    wr(32'h1); tick();
    chk("R6 enabled, flushes released", {tx_flush, rx_flush, status_hold}, 32'h1);
    wr(32'h0); tick();
    chk("R6 waiting, no nack no flush", {nack_req, tx_flush}, 32'h0);
    eng_byte_done = 1'b1; tick(); eng_byte_done = 1'b0;
    chk("R6 byte boundary does not end transmit", tx_flush, 32'h0);
    eng_xfer_done = 1'b1; tick(); eng_xfer_done = 1'b0;
    chk("R6 tx buffer discarded after transfer", tx_flush, 32'h1);
    eng_idle = 1'b1; tick();
    chk("R9 idle after transmit disable", status_hold, 32'h0);

    // R10: abort set and enable cleared in one write, bus idle
    wr(32'h1); tick();
    wr(32'h2);
    chk("R10 abort taken, enable shows 0", reg_rdata, 32'h2);
    tick(); tick();
    chk("R10 stop first", {stop_req, status_hold}, 32'h3);
    tick();
    chk("R10 irq before disable", {abort_irq, status_hold, reg_rdata[1:0]}, 32'hC);
    tick();
    chk("R10 still held after irq", status_hold, 32'h1);
    tick();
    chk("R10 disabled after abort", {status_hold, reg_rdata[1:0]}, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule